// File: doc/BRIEF.md
# Zero-Turnaround Burst SRAM Core

This block is a synchronous single-port memory with one shared data word per clock and no wait states, including at every change between reading and writing. Control, address and select inputs are registered on the rising clock edge. Read data flows combinationally out of the array during the cycle after the address edge. Write data arrives one enabled clock later than its command and is parked in a pending-write register. A read that hits the parked address is served from that register, so no idle cycles are needed at read/write transitions.

The access sequencer is a three-state machine that names the data phase of the current cycle: `ST_IDLE` (deselected), `ST_READ` and `ST_WRITE`. On a load edge (`adv_ld` low) the machine takes transition LOAD_SEL to `ST_READ` or `ST_WRITE` when the device is selected, or transition LOAD_DESEL to `ST_IDLE` when it is not. On an advance edge (`adv_ld` high) it takes transition BURST_STEP: it stays in `ST_READ` or `ST_WRITE` and steps the 2-bit burst counter, or it takes IDLE_HOLD and stays in `ST_IDLE` without effect. While `clk_en_n` is high no transition is taken. The word is 36 bits as four 9-bit lanes. The depth is the parameter `DEPTH`, a power of two of at least 8.

Top module: `nowait_burst_ram`

## Requirements
- R1: While `clk_en_n` is high, no input is sampled and every register (state, burst address, pending write) holds, so the output of the previous cycle is extended and write data presented during the stall is ignored.
- R2: A load starts an access only when `sel1_n`=0, `sel2`=1 and `sel3_n`=0. Any other combination on a load edge enters `ST_IDLE`, and `rdata_oe` is low in the following cycle. After reset, `rdata_oe` is low.
- R3: A selected load with `wr_n`=1 is a read. During the cycle after that edge, `rdata` carries the addressed word and `rdata_oe` is high.
- R4: With `burst_ilv`=0, beat n (n=0..3) of a burst accesses low address bits (start+n) mod 4, where start is `addr[1:0]` at the load. The upper address bits stay fixed.
- R5: With `burst_ilv`=1, beat n accesses low address bits start XOR n, and the upper bits stay fixed.
- R6: A selected load with `wr_n`=0 is a write. Its data is taken from `wdata` on the next enabled edge, together with `lane_wr_n`. Lane i is bits [9i+8:9i], and it is written only when `lane_wr_n[i]`=0. A lane whose select is high keeps its stored value.
- R7: `rdata_oe` is low throughout every write data phase, and is low whenever `out_en_n` is high.
- R8: An advance (`adv_ld`=1) issued while in `ST_IDLE` has no effect: the device stays idle and drives nothing.
- R9: Reads and writes may be mixed on consecutive edges. A read issued on the edge that captures a write's data, to that write's address, returns the newly written lanes merged with the stored lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset of state and pending write |
| clk_en_n | input | 1 | Active-low clock qualifier; high stalls everything |
| sel1_n | input | 1 | Chip select, active low |
| sel2 | input | 1 | Chip select, active high |
| sel3_n | input | 1 | Chip select, active low |
| adv_ld | input | 1 | 0 = load new command, 1 = advance burst |
| wr_n | input | 1 | 0 = write, 1 = read (on load) |
| lane_wr_n | input | 4 | Per-lane write selects, active low, taken with data |
| addr | input | log2(DEPTH) | Word address |
| burst_ilv | input | 1 | Static burst order: 0 linear, 1 interleaved |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| wdata | input | 36 | Write data, one enabled edge after the command |
| rdata | output | 36 | Read data (zero outside read phases) |
| rdata_oe | output | 1 | Bus drive enable for `rdata` |

## Verification
The embedded properties watch on every clock that a stall freezes the sequencer state and burst address, that a deselected load and an idle advance both end in `ST_IDLE`, and that a linear advance steps the low address bits by one with the upper bits fixed. They also check that every write data phase fills the pending register at the right address, that the drive enable never rises during a write phase or with `out_en_n` high, and that a full-lane write followed at once by a read of the same address returns the written word. Beat-by-beat interleaved ordering, partial-lane merges across all sixteen lane masks, and the commit of a parked write into the array when a later write arrives can only be shown by the bench's sweeps. The bench compares those results against its own reference array.

// File: rtl/nwb_pkg.sv
package nwb_pkg;
    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int WORD_W = LANES * LANE_W;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } phase_t;

    // Low address bits of burst beat 'step' from 'start'.
    function automatic logic [1:0] burst_low(input logic [1:0] start,
                                             input logic [1:0] step,
                                             input logic       ilv);
        return ilv ? (start ^ step) : (start + step);
    endfunction
endpackage

// File: rtl/nwb_ctrl.sv
module nwb_ctrl
    import nwb_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clk_en_n,
    input  logic          sel1_n,
    input  logic          sel2,
    input  logic          sel3_n,
    input  logic          adv_ld,
    input  logic          wr_n,
    input  logic [AW-1:0] addr,
    input  logic          burst_ilv,
    output phase_t        phase,
    output logic [AW-1:0] eff_addr,
    output logic          rd_phase,
    output logic          wr_phase
);
    phase_t        state_q, state_d;
    logic [AW-1:0] base_q, base_d;
    logic [1:0]    cnt_q, cnt_d;
    logic          selected;

    assign selected = ~sel1_n & sel2 & ~sel3_n;

    // next-state process
    always_comb begin
        state_d = state_q;
        base_d  = base_q;
        cnt_d   = cnt_q;
        if (!adv_ld) begin
            base_d  = addr;
            cnt_d   = 2'd0;
            state_d = !selected ? ST_IDLE : (wr_n ? ST_READ : ST_WRITE);
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_READ:  cnt_d   = cnt_q + 2'd1;
                ST_WRITE: cnt_d   = cnt_q + 2'd1;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
            cnt_q   <= 2'd0;
        end else if (!clk_en_n) begin
            state_q <= state_d;
            base_q  <= base_d;
            cnt_q   <= cnt_d;
        end
    end

    // output process
    always_comb begin
        phase    = state_q;
        eff_addr = {base_q[AW-1:2], burst_low(base_q[1:0], cnt_q, burst_ilv)};
        rd_phase = (state_q == ST_READ);
        wr_phase = (state_q == ST_WRITE);
    end

    p_stall_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n |=> ($stable(state_q) && $stable(base_q) && $stable(cnt_q)));

    p_deselect_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !adv_ld && !(~sel1_n & sel2 & ~sel3_n)) |=> (state_q == ST_IDLE));

    p_linear_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && adv_ld && state_q != ST_IDLE && !burst_ilv) |=>
        (burst_ilv || ((eff_addr[1:0] == $past(eff_addr[1:0]) + 2'd1) &&
                       (eff_addr[AW-1:2] == $past(eff_addr[AW-1:2])))));

    p_idle_advance_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && adv_ld && state_q == ST_IDLE) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/nwb_store.sv
module nwb_store
    import nwb_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en_n,
    input  logic              wr_phase,
    input  logic [AW-1:0]     eff_addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [LANES-1:0]  lane_wr_n,
    output logic [WORD_W-1:0] rd_word
);
    logic [WORD_W-1:0] mem [DEPTH];
    logic              pend_valid_q;
    logic [AW-1:0]     pend_addr_q;
    logic [WORD_W-1:0] pend_data_q;
    logic [LANES-1:0]  pend_be_q;
    logic              take, hit;
    logic [WORD_W-1:0] stored;

    assign take   = ~clk_en_n & wr_phase;
    assign hit    = pend_valid_q && (pend_addr_q == eff_addr);
    assign stored = mem[eff_addr];

    // Commit the parked write when the next write's data arrives.
    always_ff @(posedge clk) begin
        if (take && pend_valid_q) begin
            for (int i = 0; i < LANES; i++) begin
                if (pend_be_q[i])
                    mem[pend_addr_q][i*LANE_W +: LANE_W] <= pend_data_q[i*LANE_W +: LANE_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid_q <= 1'b0;
            pend_addr_q  <= '0;
            pend_data_q  <= '0;
            pend_be_q    <= '0;
        end else if (take) begin
            pend_valid_q <= 1'b1;
            pend_addr_q  <= eff_addr;
            pend_data_q  <= wdata;
            pend_be_q    <= ~lane_wr_n;
        end
    end

    // Per-lane coherency bypass.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign rd_word[g*LANE_W +: LANE_W] = (hit && pend_be_q[g]) ?
            pend_data_q[g*LANE_W +: LANE_W] : stored[g*LANE_W +: LANE_W];
    end

    p_pend_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (pend_valid_q && pend_addr_q == $past(eff_addr)));
endmodule

// File: rtl/nowait_burst_ram.sv
module nowait_burst_ram
    import nwb_pkg::*;
#(
    parameter  int DEPTH = 1024,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en_n,
    input  logic              sel1_n,
    input  logic              sel2,
    input  logic              sel3_n,
    input  logic              adv_ld,
    input  logic              wr_n,
    input  logic [LANES-1:0]  lane_wr_n,
    input  logic [AW-1:0]     addr,
    input  logic              burst_ilv,
    input  logic              out_en_n,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic              rdata_oe
);
    phase_t            phase;
    logic [AW-1:0]     eff_addr;
    logic              rd_phase, wr_phase;
    logic [WORD_W-1:0] rd_word;

    nwb_ctrl #(.AW(AW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n),
        .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
        .adv_ld(adv_ld), .wr_n(wr_n), .addr(addr), .burst_ilv(burst_ilv),
        .phase(phase), .eff_addr(eff_addr),
        .rd_phase(rd_phase), .wr_phase(wr_phase)
    );

    nwb_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n),
        .wr_phase(wr_phase), .eff_addr(eff_addr),
        .wdata(wdata), .lane_wr_n(lane_wr_n), .rd_word(rd_word)
    );

    assign rdata    = rd_phase ? rd_word : '0;
    assign rdata_oe = rd_phase & ~out_en_n;

    p_quiet_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == ST_WRITE) |-> !rdata_oe);

    p_quiet_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_n |-> !rdata_oe);

    p_turnaround_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && phase == ST_WRITE && !adv_ld && wr_n &&
         !sel1_n && sel2 && !sel3_n && addr == eff_addr && lane_wr_n == '0)
        |=> (rdata == $past(wdata)));
endmodule

// File: tb/nowait_burst_ram_test.sv
module nowait_burst_ram_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int AW         = 4;

    logic        clk = 1'b0;
    logic        rst_n, clk_en_n, sel1_n, sel2, sel3_n, adv_ld, wr_n;
    logic [3:0]  lane_wr_n;
    logic [AW-1:0] addr;
    logic        burst_ilv, out_en_n;
    logic [35:0] wdata, rdata;
    logic        rdata_oe;

    nowait_burst_ram #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n),
        .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
        .adv_ld(adv_ld), .wr_n(wr_n), .lane_wr_n(lane_wr_n), .addr(addr),
        .burst_ilv(burst_ilv), .out_en_n(out_en_n),
        .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    // reference model: 0 idle, 1 read, 2 write
    logic [35:0]   ref_mem [DEPTH];
    int            m_state = 0;
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_cnt = 2'd0;
    logic [35:0]   cur_wd = '0;
    logic [3:0]    cur_be = 4'hF;

    function automatic logic [AW-1:0] m_addr();
        logic [1:0] lo;
        lo = burst_ilv ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
        return {m_base[AW-1:2], lo};
    endfunction

    function automatic logic [35:0] pat(input int a, input int s);
        return {9'(a + s*16 + 1), 9'(a*3 + s + 2), 9'(a ^ s ^ 9'h155), 9'(a + 256 + s*5)};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick(input logic cen_n, input logic ld, input logic s1n, input logic s2,
                        input logic s3n, input logic wrn, input logic [AW-1:0] a,
                        input logic oen, input logic [35:0] dn, input logic [3:0] ben,
                        input string tag);
        logic        exp_oe;
        logic [35:0] exp_d;
        clk_en_n = cen_n; adv_ld = ld; sel1_n = s1n; sel2 = s2; sel3_n = s3n;
        wr_n = wrn; addr = a; out_en_n = oen;
        if (cen_n) begin
            wdata = ~cur_wd; lane_wr_n = ~cur_be;
        end else begin
            wdata = cur_wd; lane_wr_n = cur_be;
            if (m_state == 2)
                for (int i = 0; i < 4; i++)
                    if (!cur_be[i]) ref_mem[m_addr()][i*9 +: 9] = cur_wd[i*9 +: 9];
            if (!ld) begin
                m_base = a; m_cnt = 2'd0;
                m_state = (!s1n && s2 && !s3n) ? (wrn ? 1 : 2) : 0;
            end else if (m_state != 0) begin
                m_cnt = m_cnt + 2'd1;
            end
            cur_wd = dn; cur_be = ben;
        end
        exp_oe = (m_state == 1) && !oen;
        exp_d  = ref_mem[m_addr()];
        @(posedge clk);
        @(negedge clk);
        chk(rdata_oe == exp_oe, {tag, " drive"}, 36'(rdata_oe), 36'(exp_oe));
        if (exp_oe) chk(rdata == exp_d, {tag, " data"}, rdata, exp_d);
    endtask

    task automatic rd(input int a, input string tag);
        tick(0, 0, 0, 1, 0, 1, AW'(a), 0, '0, 4'hF, tag);
    endtask
    task automatic wr(input int a, input logic [35:0] d, input logic [3:0] be, input string tag);
        tick(0, 0, 0, 1, 0, 0, AW'(a), 0, d, be, tag);
    endtask
    task automatic adv(input logic [35:0] d, input logic [3:0] be, input string tag);
        tick(0, 1, 1, 0, 1, 1, '0, 0, d, be, tag);
    endtask
    task automatic nop(input string tag);
        tick(0, 0, 1, 1, 0, 1, '0, 0, '0, 4'hF, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
        rst_n = 1'b0; clk_en_n = 1'b0; sel1_n = 1'b1; sel2 = 1'b0; sel3_n = 1'b1;
        adv_ld = 1'b0; wr_n = 1'b1; lane_wr_n = 4'hF; addr = '0; burst_ilv = 1'b0;
        out_en_n = 1'b0; wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk(rdata_oe == 1'b0, "R2 reset drive", 36'(rdata_oe), 36'd0);

        // R6/R3: fill every word back to back, then read back to back
        for (int a = 0; a < DEPTH; a++) wr(a, pat(a, 0), 4'h0, "R6 fill");
        for (int a = 0; a < DEPTH; a++) rd(a, "R3 readback");

        // R9: alternating write/read, same and neighbouring address
        for (int a = 0; a < DEPTH; a++) begin
            wr(a, pat(a, 1), 4'h0, "R9 write");
            rd(a, "R9 same-address read");
            wr(a ^ 1, pat(a, 2), 4'h0, "R9 write");
            rd(a, "R9 other read");
        end

        // R6: every lane mask, bypass hit and then committed read
        for (int m = 0; m < 16; m++) begin
            wr(5, pat(m, 3), 4'(m), "R6 lanes");
            rd(5, "R6 lane bypass");
            wr(6, pat(m, 4), 4'h0, "R6 lanes");
            rd(5, "R6 lane committed");
        end

        // R4 (linear) and R5 (interleaved) bursts
        for (int ilv = 0; ilv < 2; ilv++) begin
            nop("R8 quiet");
            burst_ilv = 1'(ilv);
            for (int s = 0; s < 4; s++) begin
                wr(8 + s, pat(4*s, 5 + ilv), 4'h0, ilv ? "R5 wburst" : "R4 wburst");
                for (int b = 1; b < 4; b++)
                    adv(pat(4*s + b, 5 + ilv), 4'h0, ilv ? "R5 wburst" : "R4 wburst");
                rd(8 + ((s + 1) % 4), ilv ? "R5 rburst" : "R4 rburst");
                for (int b = 1; b < 4; b++) adv('0, 4'hF, ilv ? "R5 rburst" : "R4 rburst");
            end
        end
        nop("R8 quiet");
        burst_ilv = 1'b0;

        // R1: stall during a read and during a write data phase
        rd(3, "R1 read");
        for (int k = 0; k < 3; k++) tick(1, 0, 0, 1, 0, 0, 4'd7, 0, '0, 4'h0, "R1 stall read");
        wr(4, 36'h1_2345_6789, 4'h0, "R1 write");
        for (int k = 0; k < 2; k++) tick(1, 0, 0, 1, 0, 1, 4'd9, 0, '0, 4'h0, "R1 stall write");
        rd(4, "R1 read after stall");

        // R2: every non-selecting combination; R8: advance while idle
        for (int c = 0; c < 8; c++) begin
            if (c != 3'b010) begin
                tick(0, 0, c[2], c[1], c[0], 1, 4'd2, 0, '0, 4'hF, "R2 deselect");
                tick(0, 1, 0, 1, 0, 1, 4'd2, 0, '0, 4'hF, "R8 idle advance");
            end
        end

        // R7: output enable high masks drive; write phase never drives
        tick(0, 0, 0, 1, 0, 1, 4'd2, 1, '0, 4'hF, "R7 oe off");
        wr(2, pat(2, 9), 4'h0, "R7 write phase");
        rd(2, "R7 read after write");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule